// File: doc/BRIEF.md
# Microcode output strobe decoder

This block sits beside the microsequencer of a diskette controller. When the microprogram executes an output instruction, it presents a 3-bit output code and a 7-bit mask, M0 to M6, together with an execute strobe. The block turns that instruction into single-clock control pulses. Each code owns a small group of named strobes, and each mask bit gates one of them.

Several of the pulses act on persistent state rather than appearing only once. Four set/clear latches hold head load, memory-write inhibit, transfer acknowledge and data overrun. Two retriggerable one-shots give an active-low head-step output and a 10 ms timeout level that the microprogram can test. The raw pulse vector is also brought out so neighbouring logic can use it.

Each one-shot is a two-state machine with the states OS_IDLE and OS_RUN. The transition "trigger" takes OS_IDLE to OS_RUN and loads the full count. The transition "retrigger" is a pulse that arrives in OS_RUN: the machine stays in OS_RUN and reloads the full count. The transition "expiry" takes OS_RUN back to OS_IDLE when the count reaches zero and no pulse is present. One-shot widths are set in cycles derived from CLK_HZ: STEP_US gives the step width (1 µs by default) and TMO_US gives the timeout width (10 000 µs by default). A derived width of zero is raised to one cycle.

Top module: `ucode_strobe_decoder`

## Requirements
- R1: After synchronous reset, pulse_o is 0, hload_o, inhibit_o, overrun_o and tmo_o are 0, and ack_n_o and step_n_o are 1.
- R2: With exec_i high and code_i = 0, the pulse vector follows the mask in the same cycle: mask bit M0 drives pulse_o[0] (step), M1 drives pulse_o[1] (timeout start) and M2 drives pulse_o[2] (head load).
- R3: With exec_i high and code_i = 1, the pulse vector follows the mask in the same cycle: M1 drives pulse_o[3] (inhibit clear), M2 drives pulse_o[4] (inhibit set), M3 drives pulse_o[5] (acknowledge set) and M4 drives pulse_o[6] (overrun clear).
- R4: pulse_o is 0 whenever exec_i is low and for every code from 2 to 7. Unassigned mask bits have no effect: M3 to M6 for code 0, and M0, M5 and M6 for code 1. When exec_i is low, no latch and no one-shot changes.
- R5: Latches take their new value at the clock edge that ends the pulse cycle. Inhibit set raises inhibit_o. Inhibit clear lowers inhibit_o. Acknowledge set drives ack_n_o low, and ack_clr_i drives it high again. ovr_evt_i raises overrun_o, and overrun clear lowers it.
- R6: When a set and a clear reach the same latch in the same cycle, the clear wins.
- R7: A step pulse drives step_n_o low for exactly STEP cycles, starting in the cycle after the pulse.
- R8: A timeout-start pulse drives tmo_o high for exactly TMO cycles, starting in the cycle after the pulse.
- R9: A new trigger while a one-shot is active restarts its full duration, counted from the new trigger.
- R10: The head-load pulse sets hload_o from the next cycle on, and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_i | input | 1 | Execute strobe for the output instruction |
| code_i | input | 3 | Output code |
| mask_i | input | 7 | Mask bits M0 to M6 (bit n is Mn) |
| ack_clr_i | input | 1 | Clears the transfer-acknowledge latch |
| ovr_evt_i | input | 1 | Sets the data-overrun latch |
| pulse_o | output | 7 | Raw decoded pulses, bit order as in R2 and R3 |
| hload_o | output | 1 | Head-load latch |
| inhibit_o | output | 1 | Memory-write inhibit latch |
| ack_n_o | output | 1 | Transfer acknowledge, active low |
| overrun_o | output | 1 | Data-overrun latch |
| step_n_o | output | 1 | Head-step one-shot, active low |
| tmo_o | output | 1 | Timeout one-shot, active high |

## Verification
The decoder has no state, so a wrong mapping shows up on pulse_o in the same cycle. The bench therefore sweeps every code against every mask, with exec_i high and with it low. A latch holding the wrong value is visible on its output one edge after the pulse. This includes a latch that lets the set beat the clear. A one-shot machine stuck in OS_RUN or leaving it early shows up as a wrong low or high width, so the bench counts widths cycle by cycle, both for single triggers and for retriggers.

// File: rtl/ucsd_pkg.sv
package ucsd_pkg;

    localparam int unsigned NPULSE = 7;
    localparam int unsigned MASKW  = 7;
    localparam int unsigned CODEW  = 3;

    localparam int unsigned PI_STEP    = 0;
    localparam int unsigned PI_TMO     = 1;
    localparam int unsigned PI_HLOAD   = 2;
    localparam int unsigned PI_INH_CLR = 3;
    localparam int unsigned PI_INH_SET = 4;
    localparam int unsigned PI_ACK_SET = 5;
    localparam int unsigned PI_OVR_CLR = 6;

    localparam logic [CODEW-1:0] CODE_HEAD = 3'd0;
    localparam logic [CODEW-1:0] CODE_XFER = 3'd1;

    typedef enum logic {
        OS_IDLE = 1'b0,
        OS_RUN  = 1'b1
    } os_state_t;

endpackage

// File: rtl/ucsd_decode.sv
module ucsd_decode
    import ucsd_pkg::*;
(
    input  logic              exec_i,
    input  logic [CODEW-1:0]  code_i,
    input  logic [MASKW-1:0]  mask_i,
    output logic [NPULSE-1:0] pulse_o
);

    logic [NPULSE-1:0] sel;

    always_comb begin
        sel = '0;
        unique case (code_i)
            CODE_HEAD: begin
                sel[PI_STEP]  = mask_i[0];
                sel[PI_TMO]   = mask_i[1];
                sel[PI_HLOAD] = mask_i[2];
            end
            CODE_XFER: begin
                sel[PI_INH_CLR] = mask_i[1];
                sel[PI_INH_SET] = mask_i[2];
                sel[PI_ACK_SET] = mask_i[3];
                sel[PI_OVR_CLR] = mask_i[4];
            end
            default: sel = '0;
        endcase
    end

    assign pulse_o = exec_i ? sel : '0;

endmodule

// File: rtl/ucsd_srlatch.sv
module ucsd_srlatch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    logic q_q;

    always_ff @(posedge clk) begin
        if (rst)        q_q <= 1'b0;
        else if (clr_i) q_q <= 1'b0;
        else if (set_i) q_q <= 1'b1;
    end

    assign q_o = q_q;

endmodule

// File: rtl/ucsd_oneshot.sv
module ucsd_oneshot
    import ucsd_pkg::*;
#(
    parameter int unsigned WIDTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic active_o
);

    localparam int unsigned CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LOAD = CW'(WIDTH - 1);

    os_state_t      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            OS_IDLE: begin
                if (trig_i) begin
                    state_d = OS_RUN;
                    cnt_d   = LOAD;
                end
            end
            OS_RUN: begin
                if (trig_i) begin
                    cnt_d = LOAD;
                end else if (cnt_q == '0) begin
                    state_d = OS_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = OS_IDLE;
        endcase
    end

    always_comb begin
        active_o = (state_q == OS_RUN);
    end

endmodule

// File: rtl/ucode_strobe_decoder.sv
module ucode_strobe_decoder
    import ucsd_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned STEP_US = 1,
    parameter int unsigned TMO_US  = 10_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_i,
    input  logic [CODEW-1:0]  code_i,
    input  logic [MASKW-1:0]  mask_i,
    input  logic              ack_clr_i,
    input  logic              ovr_evt_i,
    output logic [NPULSE-1:0] pulse_o,
    output logic              hload_o,
    output logic              inhibit_o,
    output logic              ack_n_o,
    output logic              overrun_o,
    output logic              step_n_o,
    output logic              tmo_o
);

    localparam longint unsigned STEP_RAW = (64'(CLK_HZ) * 64'(STEP_US)) / 64'd1_000_000;
    localparam longint unsigned TMO_RAW  = (64'(CLK_HZ) * 64'(TMO_US)) / 64'd1_000_000;
    localparam int unsigned STEP_CYC = (STEP_RAW == 0) ? 1 : int'(STEP_RAW);
    localparam int unsigned TMO_CYC  = (TMO_RAW == 0) ? 1 : int'(TMO_RAW);

    logic [NPULSE-1:0] pulse;
    logic              ack_q;
    logic              step_act;

    ucsd_decode u_dec (
        .exec_i  (exec_i),
        .code_i  (code_i),
        .mask_i  (mask_i),
        .pulse_o (pulse)
    );

    ucsd_srlatch u_hload (
        .clk   (clk),
        .rst   (rst),
        .set_i (pulse[PI_HLOAD]),
        .clr_i (1'b0),
        .q_o   (hload_o)
    );

    ucsd_srlatch u_inhibit (
        .clk   (clk),
        .rst   (rst),
        .set_i (pulse[PI_INH_SET]),
        .clr_i (pulse[PI_INH_CLR]),
        .q_o   (inhibit_o)
    );

    ucsd_srlatch u_ack (
        .clk   (clk),
        .rst   (rst),
        .set_i (pulse[PI_ACK_SET]),
        .clr_i (ack_clr_i),
        .q_o   (ack_q)
    );

    ucsd_srlatch u_ovr (
        .clk   (clk),
        .rst   (rst),
        .set_i (ovr_evt_i),
        .clr_i (pulse[PI_OVR_CLR]),
        .q_o   (overrun_o)
    );

    ucsd_oneshot #(.WIDTH(STEP_CYC)) u_step (
        .clk      (clk),
        .rst      (rst),
        .trig_i   (pulse[PI_STEP]),
        .active_o (step_act)
    );

    ucsd_oneshot #(.WIDTH(TMO_CYC)) u_tmo (
        .clk      (clk),
        .rst      (rst),
        .trig_i   (pulse[PI_TMO]),
        .active_o (tmo_o)
    );

    assign pulse_o  = pulse;
    assign ack_n_o  = ~ack_q;
    assign step_n_o = ~step_act;

endmodule

// File: rtl/ucsd_checker.sv
module ucsd_checker
    import ucsd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              exec_i,
    input logic [CODEW-1:0]  code_i,
    input logic [MASKW-1:0]  mask_i,
    input logic              ack_clr_i,
    input logic              ovr_evt_i,
    input logic [NPULSE-1:0] pulse_o,
    input logic              hload_o,
    input logic              inhibit_o,
    input logic              ack_n_o,
    input logic              overrun_o,
    input logic              step_n_o,
    input logic              tmo_o
);

    p_quiet_no_exec_r4: assert property (@(posedge clk) disable iff (rst)
        !exec_i |-> (pulse_o == '0));

    p_quiet_other_codes_r4: assert property (@(posedge clk) disable iff (rst)
        (code_i > CODE_XFER) |-> (pulse_o == '0));

    p_step_map_r2: assert property (@(posedge clk) disable iff (rst)
        (exec_i && code_i == CODE_HEAD) |-> (pulse_o[PI_STEP] == mask_i[0]));

    p_ack_map_r3: assert property (@(posedge clk) disable iff (rst)
        (exec_i && code_i == CODE_XFER) |-> (pulse_o[PI_ACK_SET] == mask_i[3]));

    p_inh_set_r5: assert property (@(posedge clk) disable iff (rst)
        (pulse_o[PI_INH_SET] && !pulse_o[PI_INH_CLR]) |=> inhibit_o);

    p_inh_clr_wins_r6: assert property (@(posedge clk) disable iff (rst)
        pulse_o[PI_INH_CLR] |=> !inhibit_o);

    p_ovr_clr_wins_r6: assert property (@(posedge clk) disable iff (rst)
        pulse_o[PI_OVR_CLR] |=> !overrun_o);

    p_ack_clr_wins_r6: assert property (@(posedge clk) disable iff (rst)
        ack_clr_i |=> ack_n_o);

    p_step_start_r7: assert property (@(posedge clk) disable iff (rst)
        pulse_o[PI_STEP] |=> !step_n_o);

    p_tmo_start_r8: assert property (@(posedge clk) disable iff (rst)
        pulse_o[PI_TMO] |=> tmo_o);

    p_hload_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        hload_o |=> hload_o);

endmodule

bind ucode_strobe_decoder ucsd_checker u_chk (.*);

// File: tb/tb_ucode_strobe_decoder.sv
`timescale 1ns/1ps
module tb_ucode_strobe_decoder;

    localparam int unsigned CLK_HZ  = 2_000_000;
    localparam int unsigned STEP_US = 1;
    localparam int unsigned TMO_US  = 20;
    localparam int unsigned STEP_W  = CLK_HZ / 1_000_000 * STEP_US;
    localparam int unsigned TMO_W   = CLK_HZ / 1_000_000 * TMO_US;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       exec_i = 1'b0;
    logic [2:0] code_i = '0;
    logic [6:0] mask_i = '0;
    logic       ack_clr_i = 1'b0;
    logic       ovr_evt_i = 1'b0;
    logic [6:0] pulse_o;
    logic hload_o, inhibit_o, ack_n_o, overrun_o, step_n_o, tmo_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    ucode_strobe_decoder #(.CLK_HZ(CLK_HZ), .STEP_US(STEP_US), .TMO_US(TMO_US)) dut (
        .clk(clk), .rst(rst), .exec_i(exec_i), .code_i(code_i), .mask_i(mask_i),
        .ack_clr_i(ack_clr_i), .ovr_evt_i(ovr_evt_i), .pulse_o(pulse_o),
        .hload_o(hload_o), .inhibit_o(inhibit_o), .ack_n_o(ack_n_o),
        .overrun_o(overrun_o), .step_n_o(step_n_o), .tmo_o(tmo_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_pulse(input logic ex, input logic [2:0] c, input logic [6:0] m);
        logic [6:0] e;
        e = '0;
        if (ex && c == 3'd0) e = {4'b0, m[2:0]};
        if (ex && c == 3'd1) e = {m[4:1], 3'b0};
        return e;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; exec_i = 1'b0; ack_clr_i = 1'b0; ovr_evt_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic issue(input logic [2:0] c, input logic [6:0] m);
        @(negedge clk);
        exec_i = 1'b1; code_i = c; mask_i = m;
        @(negedge clk);
        exec_i = 1'b0; mask_i = '0;
    endtask

    task automatic measure(output int w, input bit use_tmo);
        w = 0;
        while ((use_tmo ? tmo_o : !step_n_o) && w < 1000) begin
            w++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(5.0 * 150_000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int w;
        do_reset();
        // R1: reset state
        chk("R1 pulse", pulse_o, 0);
        chk("R1 latches", {hload_o, inhibit_o, overrun_o, tmo_o}, 0);
        chk("R1 low-active", {ack_n_o, step_n_o}, 2'b11);

        // R2 R3 R4: exhaustive code x mask sweep, strobe high and low
        for (int ex = 0; ex < 2; ex++) begin
            for (int c = 0; c < 8; c++) begin
                for (int m = 0; m < 128; m++) begin
                    @(negedge clk);
                    exec_i = ex[0]; code_i = c[2:0]; mask_i = m[6:0];
                    #1;
                    if (!ex[0] || c > 1)
                        chk("R4 quiet", pulse_o, exp_pulse(ex[0], c[2:0], m[6:0]));
                    else if (c == 0)
                        chk("R2 code0 map", pulse_o, exp_pulse(1'b1, 3'd0, m[6:0]));
                    else
                        chk("R3 code1 map", pulse_o, exp_pulse(1'b1, 3'd1, m[6:0]));
                end
            end
        end
        @(negedge clk); exec_i = 1'b0;

        // R4: strobe low leaves latches and one-shots untouched
        do_reset();
        @(negedge clk); exec_i = 1'b0; code_i = 3'd0; mask_i = 7'h7f;
        @(negedge clk);
        chk("R4 no exec state", {hload_o, tmo_o, step_n_o}, 3'b001);
        code_i = 3'd1;
        @(negedge clk);
        chk("R4 no exec latches", {inhibit_o, ack_n_o, overrun_o}, 3'b010);
        // R4: unassigned bits
        issue(3'd0, 7'h78);
        chk("R4 unassigned code0", {hload_o, tmo_o, step_n_o}, 3'b001);
        issue(3'd1, 7'h61);
        chk("R4 unassigned code1", {inhibit_o, ack_n_o, overrun_o}, 3'b010);

        // R5 inhibit
        issue(3'd1, 7'h04);
        chk("R5 inhibit set", inhibit_o, 1);
        issue(3'd1, 7'h02);
        chk("R5 inhibit clear", inhibit_o, 0);
        issue(3'd1, 7'h04);
        issue(3'd1, 7'h06);
        chk("R6 inhibit clear wins", inhibit_o, 0);

        // R5 acknowledge
        issue(3'd1, 7'h08);
        chk("R5 ack set", ack_n_o, 0);
        @(negedge clk); ack_clr_i = 1'b1;
        @(negedge clk); ack_clr_i = 1'b0;
        chk("R5 ack clear", ack_n_o, 1);
        @(negedge clk); exec_i = 1'b1; code_i = 3'd1; mask_i = 7'h08; ack_clr_i = 1'b1;
        @(negedge clk); exec_i = 1'b0; ack_clr_i = 1'b0;
        chk("R6 ack clear wins", ack_n_o, 1);

        // R5 overrun
        @(negedge clk); ovr_evt_i = 1'b1;
        @(negedge clk); ovr_evt_i = 1'b0;
        chk("R5 overrun set", overrun_o, 1);
        issue(3'd1, 7'h10);
        chk("R5 overrun clear", overrun_o, 0);
        @(negedge clk); exec_i = 1'b1; code_i = 3'd1; mask_i = 7'h10; ovr_evt_i = 1'b1;
        @(negedge clk); exec_i = 1'b0; ovr_evt_i = 1'b0;
        chk("R6 overrun clear wins", overrun_o, 0);

        // R10 head load
        issue(3'd0, 7'h04);
        chk("R10 head load set", hload_o, 1);
        for (int m = 0; m < 128; m++) issue(3'd1, m[6:0]);
        issue(3'd0, 7'h03);
        chk("R10 head load holds", hload_o, 1);
        do_reset();
        chk("R10 head load reset", hload_o, 0);

        // R7 step width
        issue(3'd0, 7'h01);
        measure(w, 1'b0);
        chk("R7 step width", w, STEP_W);
        chk("R7 step idle", step_n_o, 1);

        // R8 timeout width
        issue(3'd0, 7'h02);
        measure(w, 1'b1);
        chk("R8 tmo width", w, TMO_W);
        chk("R8 tmo idle", tmo_o, 0);

        // R9 retrigger timeout mid-run and at its last active cycle
        issue(3'd0, 7'h02);
        repeat (9) @(negedge clk);
        chk("R9 tmo still active", tmo_o, 1);
        issue(3'd0, 7'h02);
        measure(w, 1'b1);
        chk("R9 tmo restart", w, TMO_W);
        issue(3'd0, 7'h02);
        repeat (TMO_W - 2) @(negedge clk);
        issue(3'd0, 7'h02);
        measure(w, 1'b1);
        chk("R9 tmo late restart", w, TMO_W);
        // R9 step retrigger in its first active cycle
        @(negedge clk); exec_i = 1'b1; code_i = 3'd0; mask_i = 7'h01;
        @(negedge clk);
        @(negedge clk); exec_i = 1'b0;
        measure(w, 1'b0);
        chk("R9 step restart", w, STEP_W);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule